// File: doc/BRIEF.md
# Pulse-Position Frame Aligner

This block finds where the frames start in a received pulse-position stream of L slots per frame. It needs no sync word. It relies on one rule: a valid frame carries exactly one high slot. Each slot clock edge captures one received bit into a sliding window of the last L slots. A modulo-L slot counter runs beside the window.

Each time the counter reaches its last value, the block inspects the window. If the window holds exactly one high slot, it emits a frame marker and decodes the symbol. Otherwise the counter pauses for one slot. That pause moves the block's idea of the frame boundary by one slot. Repeated pauses walk the boundary onto the true one, and once there it stays.

A lock flag reports when the alignment can be trusted. A downstream demodulator reads the slot index, the frame marker and the decoded symbol. The clock input is the already recovered slot clock, and the data bit arrives aligned to it. Any L of 4 or more works; 4 and 16 are the intended sizes.

Top module: `ppm_frame_sync`

## Requirements
- R1: While reset is high at a clock edge, every output goes to zero after that edge: frame_sync, locked, slot_idx and sym_data.
- R2: The inspection happens at the edge where slot_idx leaves L-1. If the window of the last L captured bits then holds exactly one '1', frame_sync is high for exactly one cycle after that edge, and slot_idx reads 0 in that cycle.
- R3: slot_idx is the in-frame index of the most recently captured slot. It counts 0,1,…,L-1 and wraps to 0 with no pause when the inspection succeeds.
- R4: If the inspected window holds zero '1's or two or more (adjacent pulses included), no frame_sync is given. slot_idx wraps to 0 and then stays at 0 for one extra cycle, so that counter period lasts L+1 cycles.
- R5: A stream of frames whose symbols alternate between 0 and L-1, started at any slot offset, becomes aligned. After that, slot_idx equals the transmitter's slot index of each captured bit and frame_sync marks each frame start.
- R6: Until L bits have been captured since reset, the counter wrap yields neither frame_sync nor a pause, whatever the window holds.
- R7: On frame_sync, sym_data shows the position (0 = first slot) of the single pulse in the frame just completed. sym_data holds that value until the next frame_sync.
- R8: locked rises in the same cycle as the HIT_LOCK-th consecutive frame_sync (default 4), and not before.
- R9: locked falls after the MISS_UNLOCK-th consecutive failed inspection (default 2). A single failed inspection leaves locked high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered slot clock, one rising edge per slot |
| rst | input | 1 | Synchronous active-high reset |
| ppm_in | input | 1 | Received slot value, stable around the rising edge |
| frame_sync | output | 1 | One-cycle marker of a frame start |
| locked | output | 1 | Alignment trusted |
| slot_idx | output | $clog2(SLOTS) | In-frame index of the last captured slot |
| sym_data | output | $clog2(SLOTS) | Pulse position of the last good frame |

## Verification
Two things can happen at the same edge: a failed inspection starts a one-slot pause, and it also advances the lock logic. The bench provokes this by sending a frame with two adjacent pulses while the block is aligned and locked. In the cycle after the boundary it expects no frame marker, slot_idx at 0 and locked still high. In the cycle after that it expects slot_idx to remain 0. A following alternating-symbol stream forces a second failed inspection, so locked must drop. The block must then realign and lock again with correct symbols.

// File: rtl/ppm_sync_pkg.sv
package ppm_sync_pkg;
  // outcome of one look at the slot window
  typedef enum logic [1:0] {
    EV_NONE = 2'd0,
    EV_HIT  = 2'd1,
    EV_MISS = 2'd2
  } slot_event_e;
endpackage

// File: rtl/ppm_window.sv
module ppm_window #(
  parameter int SLOTS = 16,
  parameter int IDX_W = $clog2(SLOTS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_in,
  output logic             win_filled,
  output logic             win_single,
  output logic [IDX_W-1:0] win_pos
);
  localparam int FILL_W = $clog2(SLOTS + 1);
  localparam logic [FILL_W-1:0] FILL_MAX = FILL_W'(SLOTS);

  logic [SLOTS-1:0]  sr;
  logic [FILL_W-1:0] fill_cnt;
  logic              seen_one;
  logic              seen_more;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr       <= '0;
      fill_cnt <= '0;
    end else begin
      sr <= {sr[SLOTS-2:0], bit_in};
      if (fill_cnt != FILL_MAX) fill_cnt <= fill_cnt + 1'b1;
    end
  end

  assign win_filled = (fill_cnt == FILL_MAX);

  // single-pulse detector with position of the pulse (bit 0 = newest)
  always_comb begin
    seen_one  = 1'b0;
    seen_more = 1'b0;
    win_pos   = '0;
    for (int i = 0; i < SLOTS; i++) begin
      if (sr[i]) begin
        if (seen_one) seen_more = 1'b1;
        seen_one = 1'b1;
        win_pos  = IDX_W'(i);
      end
    end
  end

  assign win_single = win_filled && seen_one && !seen_more;

  // R6: once the window has filled it stays filled until reset
  p_fill_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    win_filled |=> win_filled);
endmodule

// File: rtl/ppm_slot_counter.sv
module ppm_slot_counter #(
  parameter int SLOTS = 16,
  parameter int IDX_W = $clog2(SLOTS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             skip_req,
  output logic [IDX_W-1:0] cnt,
  output logic             carry
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(SLOTS - 1);

  logic skip_q;  // registered count-enable: high means pause one slot

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      skip_q <= 1'b0;
    end else begin
      skip_q <= skip_req;
      if (!skip_q) cnt <= carry ? '0 : cnt + 1'b1;
    end
  end

  assign carry = (cnt == LAST);

  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST);

  p_pause_holds_r4: assert property (@(posedge clk) disable iff (rst)
    skip_q |=> (cnt == $past(cnt)));
endmodule

// File: rtl/ppm_lock_tracker.sv
module ppm_lock_tracker
  import ppm_sync_pkg::*;
#(
  parameter int HIT_LOCK    = 4,
  parameter int MISS_UNLOCK = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  slot_event_e ev,
  output logic        locked
);
  localparam int HW = $clog2(HIT_LOCK + 1);
  localparam int MW = $clog2(MISS_UNLOCK + 1);
  localparam logic [HW-1:0] HIT_MAX   = HW'(HIT_LOCK);
  localparam logic [HW-1:0] HIT_EDGE  = HW'(HIT_LOCK - 1);
  localparam logic [MW-1:0] MISS_MAX  = MW'(MISS_UNLOCK);
  localparam logic [MW-1:0] MISS_EDGE = MW'(MISS_UNLOCK - 1);

  logic [HW-1:0] hit_run;
  logic [MW-1:0] miss_run;

  always_ff @(posedge clk) begin
    if (rst) begin
      hit_run  <= '0;
      miss_run <= '0;
      locked   <= 1'b0;
    end else begin
      case (ev)
        EV_HIT: begin
          miss_run <= '0;
          if (hit_run != HIT_MAX) hit_run <= hit_run + 1'b1;
          if (hit_run >= HIT_EDGE) locked <= 1'b1;
        end
        EV_MISS: begin
          hit_run <= '0;
          if (miss_run != MISS_MAX) miss_run <= miss_run + 1'b1;
          if (miss_run >= MISS_EDGE) locked <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  p_lock_on_hit_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> ($past(ev) == EV_HIT));

  p_unlock_on_miss_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(locked) |-> ($past(ev) == EV_MISS));
endmodule

// File: rtl/ppm_frame_sync.sv
module ppm_frame_sync
  import ppm_sync_pkg::*;
#(
  parameter int SLOTS       = 16,
  parameter int HIT_LOCK    = 4,
  parameter int MISS_UNLOCK = 2,
  parameter int IDX_W       = $clog2(SLOTS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ppm_in,
  output logic             frame_sync,
  output logic             locked,
  output logic [IDX_W-1:0] slot_idx,
  output logic [IDX_W-1:0] sym_data
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(SLOTS - 1);

  logic             win_filled;
  logic             win_single;
  logic [IDX_W-1:0] win_pos;
  logic             carry;
  slot_event_e      ev;

  ppm_window #(.SLOTS(SLOTS), .IDX_W(IDX_W)) u_window (
    .clk        (clk),
    .rst        (rst),
    .bit_in     (ppm_in),
    .win_filled (win_filled),
    .win_single (win_single),
    .win_pos    (win_pos)
  );

  // inspection only at the counter wrap and only after the window filled
  always_comb begin
    if (carry && win_filled) ev = win_single ? EV_HIT : EV_MISS;
    else                     ev = EV_NONE;
  end

  ppm_slot_counter #(.SLOTS(SLOTS), .IDX_W(IDX_W)) u_counter (
    .clk      (clk),
    .rst      (rst),
    .skip_req (ev == EV_MISS),
    .cnt      (slot_idx),
    .carry    (carry)
  );

  ppm_lock_tracker #(.HIT_LOCK(HIT_LOCK), .MISS_UNLOCK(MISS_UNLOCK)) u_lock (
    .clk    (clk),
    .rst    (rst),
    .ev     (ev),
    .locked (locked)
  );

  // window bit 0 is the newest slot, so the pulse position is mirrored
  always_ff @(posedge clk) begin
    if (rst) begin
      frame_sync <= 1'b0;
      sym_data   <= '0;
    end else begin
      frame_sync <= (ev == EV_HIT);
      if (ev == EV_HIT) sym_data <= LAST - win_pos;
    end
  end

  p_sync_at_start_r2: assert property (@(posedge clk) disable iff (rst)
    frame_sync |-> (slot_idx == '0));

  p_sync_one_cycle_r2: assert property (@(posedge clk) disable iff (rst)
    frame_sync |=> !frame_sync);

  p_miss_double_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (ev == EV_MISS) |=> (slot_idx == '0) ##1 (slot_idx == '0));

  p_sym_held_r7: assert property (@(posedge clk) disable iff (rst)
    !frame_sync |-> $stable(sym_data));
endmodule

// File: tb/ppm_frame_sync_tb.sv
`timescale 1ns/1ps
module ppm_frame_sync_tb;
  localparam int L  = 16;
  localparam int HL = 4;
  localparam int W  = $clog2(L);

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         ppm_in = 1'b0;
  logic         frame_sync, locked;
  logic [W-1:0] slot_idx, sym_data;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;  // 125 MHz

  ppm_frame_sync #(.SLOTS(L), .HIT_LOCK(HL), .MISS_UNLOCK(2)) u_dut (
    .clk(clk), .rst(rst), .ppm_in(ppm_in),
    .frame_sync(frame_sync), .locked(locked),
    .slot_idx(slot_idx), .sym_data(sym_data)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push(input logic b);
    ppm_in = b;
    @(posedge clk);
    #2;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    ppm_in = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    rst = 1'b0;
  endtask

  // one aligned frame with every slot checked
  task automatic send_checked(input int sym, input int prev_sym,
                              input bit have_prev, input int hits_before);
    for (int s = 0; s < L; s++) begin
      int hits;
      push(s == sym);
      hits = hits_before + (have_prev ? 1 : 0);
      chk("R2 frame_sync", int'(frame_sync), (have_prev && s == 0) ? 1 : 0);
      chk("R3 slot_idx", int'(slot_idx), s);
      if (have_prev) chk("R7 sym_data", int'(sym_data), prev_sym);
      chk("R8 locked", int'(locked), (hits >= HL) ? 1 : 0);
    end
  endtask

  task automatic send_plain(input int sym);
    for (int s = 0; s < L; s++) push(s == sym);
  endtask

  task automatic test_reset();
    do_reset();
    chk("R1 frame_sync", int'(frame_sync), 0);
    chk("R1 locked", int'(locked), 0);
    chk("R1 slot_idx", int'(slot_idx), 0);
    chk("R1 sym_data", int'(sym_data), 0);
  endtask

  task automatic test_prefill();
    int sync_seen = 0;
    do_reset();
    push(1'b1);
    for (int k = 2; k <= L; k++) begin
      push(1'b0);
      if (frame_sync) sync_seen++;
    end
    chk("R6 no sync before fill", sync_seen, 0);
    chk("R6 no pause before fill", int'(slot_idx), 0);
    push(1'b0);
    chk("R6 counter advanced", int'(slot_idx), 1);
    for (int k = L + 2; k <= 2 * L; k++) push(1'b0);
    chk("R4 empty window wraps", int'(slot_idx), 0);
    chk("R4 no sync on empty", int'(frame_sync), 0);
    push(1'b0);
    chk("R4 pause holds zero", int'(slot_idx), 0);
    push(1'b0);
    chk("R4 resumes", int'(slot_idx), 1);
  endtask

  task automatic test_zero_period();
    int first = -1, second = -1, syncs = 0, locks = 0;
    do_reset();
    for (int k = 0; k < 3 * L; k++) push(1'b0);
    for (int n = 0; n < 4 * L; n++) begin
      push(1'b0);
      if (frame_sync) syncs++;
      if (locked) locks++;
      if (slot_idx == W'(L - 1)) begin
        if (first < 0) first = n;
        else if (second < 0) second = n;
      end
    end
    chk("R4 period with misses", second - first, L + 1);
    chk("R4 no sync on zeros", syncs, 0);
    chk("R8 no lock on zeros", locks, 0);
  endtask

  task automatic test_aligned_lock();
    int prev = 0;
    do_reset();
    for (int k = 0; k < L - 1; k++) push(1'b0);
    for (int f = 1; f <= 12; f++) begin
      int sym;
      sym = (f <= 6) ? ((f % 2 == 1) ? 0 : L - 1) : ((3 * f + 5) % L);
      send_checked(sym, prev, f >= 2, (f >= 2) ? f - 2 : 0);
      prev = sym;
    end
  endtask

  int last_sym;

  task automatic test_converge();
    do_reset();
    for (int k = 0; k < 5; k++) push(1'b0);
    for (int f = 0; f < 2 * L; f++) send_plain((f % 2 == 0) ? 0 : L - 1);
    last_sym = L - 1;
    for (int f = 0; f < 6; f++) begin
      int sym;
      sym = (7 * f + 2) % L;
      send_checked(sym, last_sym, 1'b1, 100);  // R5 aligned tracking
      last_sym = sym;
    end
  endtask

  task automatic test_corrupt();
    int dropped = 0;
    // frame with two adjacent pulses while locked
    for (int s = 0; s < L; s++) push(s == 2 || s == 3);
    push(1'b1);  // slot 0 of a symbol-0 frame
    chk("R4 no sync on double pulse", int'(frame_sync), 0);
    chk("R9 one miss keeps lock", int'(locked), 1);
    chk("R4 wrap after double pulse", int'(slot_idx), 0);
    push(1'b0);
    chk("R4 pause after double pulse", int'(slot_idx), 0);
    for (int s = 2; s < L; s++) push(1'b0);
    for (int f = 0; f < 2; f++) begin
      for (int s = 0; s < L; s++) begin
        push(s == ((f % 2 == 0) ? L - 1 : 0));
        if (!locked) dropped = 1;
      end
    end
    chk("R9 second miss drops lock", dropped, 1);
    for (int f = 0; f < 2 * L; f++) send_plain((f % 2 == 0) ? L - 1 : 0);
    last_sym = 0;
    for (int f = 0; f < 4; f++) begin
      int sym;
      sym = (5 * f + 9) % L;
      send_checked(sym, last_sym, 1'b1, 100);  // R5 relock after loss
      last_sym = sym;
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    @(negedge clk);
    test_reset();
    test_prefill();
    test_zero_period();
    test_aligned_lock();
    test_converge();
    test_corrupt();
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end
endmodule